// File: doc/BRIEF.md
# Multiplex-Aware Display RAM Write Pointer

This block sits between a serial-bus front end and a display RAM. The RAM is made of 4-bit words, and each bit of a word drives one backplane row. A pointer command places a write pointer. Each display byte that arrives is then cut into groups of 1, 2, 3 or 4 bits, as the multiplex drive mode selects. The groups are written into consecutive RAM words, with each group's bits placed at the matching row positions. The byte is committed as soon as it has arrived. The RAM port carries a per-row write mask, so rows that a mode does not touch keep their contents.

Bytes enter over a valid/ready stream. `byte_ready` is high whenever the block is idle. A byte transfers on a clock edge where `byte_valid` and `byte_ready` are both high. The sender must hold `byte_data` while it waits. While the words of a byte are being written, `byte_ready` stays low. The pointer-load, abort and mode pins are plain control inputs.

The pointer covers a 40-word RAM and wraps from the last word back to word 0. An aborted bus transfer marks the pointer invalid. Bytes that arrive while the pointer is invalid are discarded until the next pointer load.

Top module: `dram_scatter_writer`

## Requirements
- R1: After reset the pointer is 0, `ptr_invalid` is low, `byte_ready` is high and `ram_we` is low.
- R2: In static mode (`mux_mode` = 0) a byte fills row 0 of 8 successive words. Byte bit 7 goes to the lowest address, and the pointer advances by 8.
- R3: In two-row mode (`mux_mode` = 1) a byte fills rows 0 and 1 of 4 successive words. In each word, the earlier (more significant) bit of the pair goes to row 0. The pointer advances by 4.
- R4: In three-row mode (`mux_mode` = 2) the first two words receive bits 7..5 and 4..2 in rows 0..2. The third word receives bits 1 and 0 in rows 0 and 1 only. The pointer advances by 3.
- R5: In four-row mode (`mux_mode` = 3) word 0 gets bits 7..4 and word 1 gets bits 3..0, with the more significant bit in the lower row (bit 7 to row 0). The pointer advances by 2.
- R6: Every write sets `ram_wmask` only for the rows that the write carries. A row outside the mode's group is never written, so it keeps its old value.
- R7: A byte accepted at edge N produces one write per cycle in the cycles after edge N, with `busy` high, for exactly as many cycles as the mode needs (8, 4, 3 or 2). `byte_ready` is high again in the cycle after the last write.
- R8: `ptr_load` sets the pointer to `ptr_value`, or to `ptr_value` − 40 when the value is 40 or more. A byte accepted in the same cycle starts at the loaded value. A load during writes changes only the pointer, and the byte in flight keeps its addresses.
- R9: Word addresses and the pointer wrap from 39 to 0.
- R10: `xfer_abort` sets `ptr_invalid`, which stays set until a `ptr_load`. If both arrive in the same cycle, the load wins.
- R11: A byte accepted while `ptr_invalid` is set, or in a cycle with `xfer_abort` and no `ptr_load`, is discarded. It causes no write and leaves the pointer unchanged.
- R12: The mode is sampled when a byte is accepted. Changing `mux_mode` during that byte's writes has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | A display byte is offered |
| byte_ready | output | 1 | Block can accept a byte |
| byte_data | input | 8 | Display byte, MSB first |
| ptr_load | input | 1 | Load the pointer from `ptr_value` |
| ptr_value | input | 6 | New pointer value |
| xfer_abort | input | 1 | Bus transfer aborted; pointer becomes invalid |
| mux_mode | input | 2 | 0 static, 1 two-row, 2 three-row, 3 four-row |
| ptr_cur | output | 6 | Current pointer |
| ptr_invalid | output | 1 | Pointer invalid since an abort |
| busy | output | 1 | Words of a byte are being written |
| ram_we | output | 1 | RAM word write strobe |
| ram_addr | output | 6 | RAM word address |
| ram_wdata | output | 4 | Row data for the word |
| ram_wmask | output | 4 | Per-row write enable |

## Verification
The first RAM write is due in the cycle right after the accepting edge. The remaining writes follow one per cycle, and `byte_ready` returns one cycle after the last write. The pointer and the invalid flag change at the edge that accepts, loads or aborts. The bench drives its inputs at the falling edge and evaluates them 1 ns later. Its model advances one step per clock, so it compares each write in the cycle it is due and looks at the pointer and the flag only while the block is idle. The whole RAM image is compared once each byte has finished.

// File: rtl/dram_wr_pkg.sv
package dram_wr_pkg;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_ROWS2  = 2'd1,
    MODE_ROWS3  = 2'd2,
    MODE_ROWS4  = 2'd3
  } mux_mode_e;

  // Bits carried per word in a given mode
  function automatic int unsigned group_bits(mux_mode_e m);
    return {30'd0, m} + 32'd1;
  endfunction

  // Words touched by one byte of width bw
  function automatic int unsigned words_per_byte(mux_mode_e m, int unsigned bw);
    int unsigned g;
    g = group_bits(m);
    return (bw + g - 1) / g;
  endfunction

endpackage

// File: rtl/dram_ptr_unit.sv
module dram_ptr_unit
  import dram_wr_pkg::*;
#(
  parameter int unsigned RAM_WORDS = 40,
  parameter int unsigned PTR_W     = 6,
  localparam int unsigned SUM_W    = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  input  logic             abort_i,
  input  logic             adv_i,
  input  logic [PTR_W-1:0] adv_step_i,
  output logic [PTR_W-1:0] base_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             invalid_o
);

  logic [PTR_W-1:0] ptr_q;
  logic             inv_q;
  logic [PTR_W-1:0] load_wrapped;
  logic [SUM_W-1:0] adv_sum;
  logic [PTR_W-1:0] adv_wrapped;

  function automatic logic [PTR_W-1:0] wrap(input logic [SUM_W-1:0] v);
    if (v >= SUM_W'(RAM_WORDS)) return PTR_W'(v - SUM_W'(RAM_WORDS));
    return PTR_W'(v);
  endfunction

  always_comb begin
    load_wrapped = wrap({1'b0, load_val_i});
    base_o       = load_i ? load_wrapped : ptr_q;
    adv_sum      = {1'b0, base_o} + {1'b0, adv_step_i};
    adv_wrapped  = wrap(adv_sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      inv_q <= 1'b0;
    end else begin
      if (adv_i)       ptr_q <= adv_wrapped;
      else if (load_i) ptr_q <= load_wrapped;
      if (load_i)       inv_q <= 1'b0;
      else if (abort_i) inv_q <= 1'b1;
    end
  end

  assign ptr_o     = ptr_q;
  assign invalid_o = inv_q;

endmodule

// File: rtl/dram_write_seq.sv
module dram_write_seq
  import dram_wr_pkg::*;
#(
  parameter int unsigned RAM_WORDS = 40,
  parameter int unsigned PTR_W     = 6,
  parameter int unsigned BYTE_W    = 8,
  localparam int unsigned IDX_W    = (BYTE_W > 2) ? $clog2(BYTE_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PTR_W-1:0]  start_addr_i,
  input  logic [BYTE_W-1:0] start_byte_i,
  input  mux_mode_e         start_mode_i,
  output logic              busy_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PTR_W-1:0]  addr_o,
  output logic [BYTE_W-1:0] byte_o,
  output mux_mode_e         mode_o
);

  logic              busy_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PTR_W-1:0]  addr_q;
  logic [BYTE_W-1:0] byte_q;
  mux_mode_e         mode_q;
  logic [IDX_W-1:0]  last_idx;
  logic [PTR_W-1:0]  addr_next;

  always_comb begin
    last_idx  = IDX_W'(words_per_byte(mode_q, BYTE_W) - 1);
    addr_next = (addr_q == PTR_W'(RAM_WORDS - 1)) ? '0 : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      addr_q <= '0;
      byte_q <= '0;
      mode_q <= MODE_STATIC;
    end else if (busy_q) begin
      if (idx_q == last_idx) begin
        busy_q <= 1'b0;
      end else begin
        idx_q  <= idx_q + 1'b1;
        addr_q <= addr_next;
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      addr_q <= start_addr_i;
      byte_q <= start_byte_i;
      mode_q <= start_mode_i;
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign addr_o = addr_q;
  assign byte_o = byte_q;
  assign mode_o = mode_q;

endmodule

// File: rtl/dram_bit_scatter.sv
module dram_bit_scatter
  import dram_wr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ROWS   = 4,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  mux_mode_e         mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ROWS-1:0]   wdata_o,
  output logic [ROWS-1:0]   wmask_o
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    int unsigned g;
    int unsigned pos;
    logic        hit;
    logic [BYTE_W-1:0] shifted;
    always_comb begin
      g       = group_bits(mode_i);
      pos     = 32'(idx_i) * g + r;
      hit     = (r < g) && (pos < BYTE_W);
      shifted = hit ? (byte_i >> (BYTE_W - 1 - pos)) : '0;
      wmask_o[r] = hit;
      wdata_o[r] = shifted[0];
    end
  end

endmodule

// File: rtl/dram_scatter_writer.sv
module dram_scatter_writer
  import dram_wr_pkg::*;
#(
  parameter int unsigned RAM_WORDS = 40,
  parameter int unsigned PTR_W     = 6,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned ROWS      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              ptr_load,
  input  logic [PTR_W-1:0]  ptr_value,
  input  logic              xfer_abort,
  input  logic [1:0]        mux_mode,
  output logic [PTR_W-1:0]  ptr_cur,
  output logic              ptr_invalid,
  output logic              busy,
  output logic              ram_we,
  output logic [PTR_W-1:0]  ram_addr,
  output logic [ROWS-1:0]   ram_wdata,
  output logic [ROWS-1:0]   ram_wmask
);

  localparam int unsigned IDX_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;

  mux_mode_e         mode_in;
  logic              take;
  logic              ptr_ok;
  logic              start;
  logic [PTR_W-1:0]  base_ptr;
  logic [PTR_W-1:0]  step;
  logic              seq_busy;
  logic [IDX_W-1:0]  seq_idx;
  logic [PTR_W-1:0]  seq_addr;
  logic [BYTE_W-1:0] seq_byte;
  mux_mode_e         seq_mode;

  always_comb begin
    mode_in = mux_mode_e'(mux_mode);
    take    = byte_valid && !seq_busy;
    ptr_ok  = ptr_load || (!ptr_invalid && !xfer_abort);
    start   = take && ptr_ok;
    step    = PTR_W'(words_per_byte(mode_in, BYTE_W));
  end

  dram_ptr_unit #(
    .RAM_WORDS (RAM_WORDS),
    .PTR_W     (PTR_W)
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ptr_load),
    .load_val_i (ptr_value),
    .abort_i    (xfer_abort),
    .adv_i      (start),
    .adv_step_i (step),
    .base_o     (base_ptr),
    .ptr_o      (ptr_cur),
    .invalid_o  (ptr_invalid)
  );

  dram_write_seq #(
    .RAM_WORDS (RAM_WORDS),
    .PTR_W     (PTR_W),
    .BYTE_W    (BYTE_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .start_addr_i (base_ptr),
    .start_byte_i (byte_data),
    .start_mode_i (mode_in),
    .busy_o       (seq_busy),
    .idx_o        (seq_idx),
    .addr_o       (seq_addr),
    .byte_o       (seq_byte),
    .mode_o       (seq_mode)
  );

  dram_bit_scatter #(
    .BYTE_W (BYTE_W),
    .ROWS   (ROWS),
    .IDX_W  (IDX_W)
  ) u_scatter (
    .byte_i  (seq_byte),
    .mode_i  (seq_mode),
    .idx_i   (seq_idx),
    .wdata_o (ram_wdata),
    .wmask_o (ram_wmask)
  );

  assign byte_ready = !seq_busy;
  assign busy       = seq_busy;
  assign ram_we     = seq_busy;
  assign ram_addr   = seq_addr;

endmodule

// File: rtl/dram_scatter_writer_chk.sv
module dram_scatter_writer_chk #(
  parameter int unsigned RAM_WORDS = 40,
  parameter int unsigned PTR_W     = 6,
  parameter int unsigned ROWS      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_valid,
  input logic             byte_ready,
  input logic             ptr_load,
  input logic             xfer_abort,
  input logic             ptr_invalid,
  input logic             busy,
  input logic             ram_we,
  input logic [PTR_W-1:0] ram_addr,
  input logic [ROWS-1:0]  ram_wmask
);

  logic acc_ok;
  logic acc_drop;
  assign acc_ok   = byte_valid && byte_ready && (ptr_load || (!ptr_invalid && !xfer_abort));
  assign acc_drop = byte_valid && byte_ready && !ptr_load && (ptr_invalid || xfer_abort);

  // R7
  accept_starts_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> (ram_we && busy && !byte_ready));

  // R7
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> !ram_we);

  // R9
  addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr < PTR_W'(RAM_WORDS)));

  // R9
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && $past(ram_we)) |->
      (ram_addr == (($past(ram_addr) == PTR_W'(RAM_WORDS - 1)) ? '0 : $past(ram_addr) + 1'b1)));

  // R6
  mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_wmask != '0));

  // R10
  abort_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_abort && !ptr_load) |=> ptr_invalid);

  // R10
  load_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> !ptr_invalid);

  // R11
  drop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_drop |=> !ram_we);

endmodule

bind dram_scatter_writer dram_scatter_writer_chk #(
  .RAM_WORDS (RAM_WORDS),
  .PTR_W     (PTR_W),
  .ROWS      (ROWS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .byte_valid  (byte_valid),
  .byte_ready  (byte_ready),
  .ptr_load    (ptr_load),
  .xfer_abort  (xfer_abort),
  .ptr_invalid (ptr_invalid),
  .busy        (busy),
  .ram_we      (ram_we),
  .ram_addr    (ram_addr),
  .ram_wmask   (ram_wmask)
);

// File: tb/dram_scatter_writer_bench.sv
module dram_scatter_writer_bench;

  localparam int NW = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_valid = 1'b0;
  logic       byte_ready;
  logic [7:0] byte_data = '0;
  logic       ptr_load = 1'b0;
  logic [5:0] ptr_value = '0;
  logic       xfer_abort = 1'b0;
  logic [1:0] mux_mode = '0;
  logic [5:0] ptr_cur;
  logic       ptr_invalid;
  logic       busy;
  logic       ram_we;
  logic [5:0] ram_addr;
  logic [3:0] ram_wdata;
  logic [3:0] ram_wmask;

  always #5 clk = ~clk;

  dram_scatter_writer u_dram_scatter_writer (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .ptr_load(ptr_load), .ptr_value(ptr_value),
    .xfer_abort(xfer_abort), .mux_mode(mux_mode), .ptr_cur(ptr_cur),
    .ptr_invalid(ptr_invalid), .busy(busy), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_wmask(ram_wmask)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [3:0] dut_ram [NW];
  logic [3:0] mdl_ram [NW];
  int         exp_ptr = 0;
  bit         exp_inv = 0;
  int         busy_left = 0;
  int         wr_k = 0;
  int         q_addr [8];
  logic [3:0] q_data [8];
  logic [3:0] q_mask [8];

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int wrapv(int v);
    return (v >= NW) ? v - NW : v;
  endfunction

  function automatic int nwords(int m);
    return (8 + m) / (m + 1);
  endfunction

  // Expected word k of a byte: row r carries byte bit 7-(k*g+r)
  function automatic logic [7:0] word_of(logic [7:0] b, int m, int k);
    logic [3:0] d, msk;
    int g, pos;
    g = m + 1; d = '0; msk = '0;
    for (int r = 0; r < 4; r++) begin
      pos = k * g + r;
      if (r < g && pos < 8) begin
        msk[r] = 1'b1;
        d[r]   = b[7 - pos];
      end
    end
    return {msk, d};
  endfunction

  task automatic compare_ram(string tag);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < NW; i++)
      if (dut_ram[i] !== mdl_ram[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    tests++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: RAM word %0d actual %0h expected %0h", tag, first,
               dut_ram[first], mdl_ram[first]);
    end
  endtask

  // One clock: evaluate settled pre-edge values, update model, wait next negedge
  task automatic tick();
    int base, m;
    bit ok;
    logic [7:0] w;
    #1;
    check("R7 ready", int'(byte_ready), int'(busy_left == 0));
    if (busy_left == 0 && !ram_we) begin
      check("R8 pointer", int'(ptr_cur), exp_ptr);
      check("R10 flag", int'(ptr_invalid), int'(exp_inv));
    end
    if (ram_we) begin
      if (busy_left == 0) check("R11 unexpected write", 1, 0);
      else begin
        check("R9 addr", int'(ram_addr), q_addr[wr_k]);
        check("R2-word data", int'(ram_wdata & ram_wmask), int'(q_data[wr_k]));
        check("R6 mask", int'(ram_wmask), int'(q_mask[wr_k]));
      end
      for (int r = 0; r < 4; r++)
        if (ram_wmask[r] && ram_addr < NW) dut_ram[ram_addr][r] = ram_wdata[r];
      if (busy_left > 0) begin
        busy_left--;
        wr_k++;
        if (busy_left == 0) compare_ram("R12 ram image");
      end
    end else if (busy_left > 0) begin
      check("R7 write missing", 0, 1);
      busy_left = 0;
    end
    if (byte_valid && byte_ready) begin
      ok = ptr_load || (!exp_inv && !xfer_abort);
      if (ok) begin
        base = ptr_load ? wrapv(int'(ptr_value)) : exp_ptr;
        m = int'(mux_mode);
        busy_left = nwords(m);
        wr_k = 0;
        for (int k = 0; k < busy_left; k++) begin
          w = word_of(byte_data, m, k);
          q_addr[k] = wrapv(base + k);
          q_data[k] = w[3:0];
          q_mask[k] = w[7:4];
          for (int r = 0; r < 4; r++)
            if (w[4 + r]) mdl_ram[q_addr[k]][r] = w[r];
        end
        exp_ptr = wrapv(base + busy_left);
      end else if (ptr_load) exp_ptr = wrapv(int'(ptr_value));
    end else if (ptr_load) exp_ptr = wrapv(int'(ptr_value));
    if (ptr_load) exp_inv = 0;
    else if (xfer_abort) exp_inv = 1;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20 && busy_left != 0; i++) tick();
    tick();
  endtask

  task automatic send(logic [7:0] b, int m);
    byte_valid = 1'b1; byte_data = b; mux_mode = 2'(m);
    tick();
    byte_valid = 1'b0;
    mux_mode = 2'($urandom);
    wait_idle();
  endtask

  task automatic load(int v);
    ptr_load = 1'b1; ptr_value = 6'(v);
    tick();
    ptr_load = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    for (int i = 0; i < NW; i++) begin
      dut_ram[i] = 4'($urandom);
      mdl_ram[i] = dut_ram[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 ready", int'(byte_ready), 1);
    check("R1 pointer", int'(ptr_cur), 0);
    check("R1 flag", int'(ptr_invalid), 0);
    check("R1 we", int'(ram_we), 0);
    @(negedge clk);

    // R2 static with wrap (R9): start at 38
    load(38);
    send(8'hA5, 0);
    check("R9 pointer wrap", int'(ptr_cur), 6);
    check("R2 word38 row0", int'(dut_ram[38][0]), 1);
    check("R2 word39 row0", int'(dut_ram[39][0]), 0);

    // R3 two-row
    load(20);
    send(8'hB4, 1);
    check("R3 pointer", int'(ptr_cur), 24);
    check("R3 word20 rows", int'(dut_ram[20][1:0]), 2'b01);

    // R4 three-row, R6 untouched rows kept
    for (int i = 10; i < 13; i++) begin dut_ram[i] = 4'hF; mdl_ram[i] = 4'hF; end
    load(10);
    send(8'h00, 2);
    check("R4 word10", int'(dut_ram[10]), 4'h8);
    check("R4 word12", int'(dut_ram[12]), 4'hC);
    check("R4 pointer", int'(ptr_cur), 13);

    // R5 four-row
    load(30);
    send(8'h1E, 3);
    check("R5 word30", int'(dut_ram[30]), 4'h8);
    check("R5 word31", int'(dut_ram[31]), 4'h7);
    check("R5 pointer", int'(ptr_cur), 32);

    // R8 load of 45 reduces to 5; load during writes
    load(45);
    check("R8 reduced load", int'(ptr_cur), 5);
    byte_valid = 1'b1; byte_data = 8'h3C; mux_mode = 2'd0;
    tick();
    byte_valid = 1'b0;
    tick();
    load(33);
    wait_idle();
    check("R8 load during writes", int'(ptr_cur), 33);

    // R10/R11 abort then discarded byte
    xfer_abort = 1'b1; tick(); xfer_abort = 1'b0;
    check("R10 flag set", int'(ptr_invalid), 1);
    send(8'hFF, 3);
    check("R11 pointer kept", int'(ptr_cur), 33);
    ptr_load = 1'b1; ptr_value = 6'd2; xfer_abort = 1'b1;
    tick();
    ptr_load = 1'b0; xfer_abort = 1'b0;
    check("R10 load wins", int'(ptr_invalid), 0);

    // Random phase
    for (int c = 0; c < 4000; c++) begin
      byte_valid = 1'($urandom);
      byte_data  = 8'($urandom);
      mux_mode   = 2'($urandom);
      ptr_load   = ($urandom % 12) == 0;
      ptr_value  = 6'($urandom);
      xfer_abort = ($urandom % 30) == 0;
      tick();
    end
    byte_valid = 1'b0; ptr_load = 1'b0; xfer_abort = 1'b0;
    wait_idle();
    compare_ram("R12 final ram");
    done = 1;
    finish_run();
  end

endmodule